// File: doc/BRIEF.md
# Acquisition Sample Buffer with Active-Low Status Flags

This block sits between an analog-to-digital converter and a register-mapped host read port. Each conversion result (16 bits by default) is written into a first-in first-out store of 1024 entries. The host pops one sample per read strobe. The block reports how full the store is through a status byte, where empty, half-full and full are active-low flags. The same byte carries the converter busy flag, also active-low, and the currently programmed input range code in its low bits.

An interrupt request output can follow one of two sources. The first is a one-cycle pulse after each conversion strobe. The second is the half-full level, which lets the host drain a block of samples per interrupt. A disable control clears the store while it is held high. Pulsing it from enable to disable and back to enable is the flush sequence. A write that finds the store full is dropped and sets a sticky overflow flag, which only a flush clears.

Top module: `acq_sample_fifo`

## Requirements
- R1: After reset the store is empty: statusByte bit 4 is 0, bits 5 and 6 are 1, overflow is 0 and rdData is 0.
- R2: Samples are returned on rdData in the order in which they were accepted.
- R3: statusByte is packed as follows. Bit 7 = NOT convBusy. Bit 6 = 0 when occupancy equals the depth. Bit 5 = 0 when occupancy is at least half the depth. Bit 4 = 0 when occupancy is zero. Bit 3 = 0. Bits 2:0 = rangeCode. The flag bits reflect the occupancy after the most recent clock edge.
- R4: With the default depth, the half-full bit (bit 5) is 1 at 511 entries and 0 at 512 entries.
- R5: A write while the store holds 1024 entries is dropped, and the stored data is unchanged. The write sets overflow, which stays 1 until a flush.
- R6: A read while the store is empty leaves rdData unchanged and moves no pointer. A later write followed by a read returns the newly written sample.
- R7: While fifoDisable is 1, the store is emptied, overflow is cleared and writes are ignored. After fifoDisable returns to 0, the store remains empty.
- R8: With irqSrcSel = 0, irqReq is 1 for the cycle after each wrStrobe taken while enabled, even if that write was dropped. With irqSrcSel = 1, irqReq is 1 exactly while occupancy is at least half the depth.
- R9: A read and a write in the same cycle on a non-empty, non-full store both take effect, and the occupancy is unchanged.
- R10: rdData takes the popped sample at the clock edge that accepts the read, and holds it until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | Conversion result valid, write request |
| wrData | input | DATA_W | Conversion result |
| rdStrobe | input | 1 | Host read request, pops one sample |
| rdData | output | DATA_W | Last popped sample |
| fifoDisable | input | 1 | 1 holds the store empty, 0 enables it |
| irqSrcSel | input | 1 | Interrupt source: 0 conversion pulse, 1 half-full |
| rangeCode | input | RANGE_W | Programmed input range, echoed in status |
| convBusy | input | 1 | Converter busy, echoed active-low in status |
| statusByte | output | 8 | Active-low flags and range readback |
| overflow | output | 1 | Sticky dropped-write flag |
| irqReq | output | 1 | Interrupt request |

## Verification
An occupancy counter that drifts from the true number of entries shows up in the flag bits of statusByte in the same cycle. It is caught at the next boundary crossing, either at 512 or at 1024 entries. A read or write pointer that wraps incorrectly does not show at once. It appears as a wrong or out-of-order value on rdData at the first read after the pointer passes the end of the store, which takes at least 1024 accepted writes. For this reason, one directed pass fills the store completely and drains it. Overflow and flush errors show in overflow and in the empty bit one cycle after the offending strobe.

// File: rtl/acq_fifo_pkg.sv
package acq_fifo_pkg;
  // positions of the active-low flags inside the status readback byte
  localparam int STAT_EMPTY_BIT = 4;
  localparam int STAT_HALF_BIT  = 5;
  localparam int STAT_FULL_BIT  = 6;
  localparam int STAT_BUSY_BIT  = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrobe_t;
endpackage

// File: rtl/acq_fifo_ctrl.sv
module acq_fifo_ctrl
  import acq_fifo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic              fifoDisable,
  output fifoStrobe_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyFlag,
  output logic              halfFlag,
  output logic              fullFlag,
  output logic              overflow,
  output logic              eocPulse
);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0]  HALF_CNT = CNT_W'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] LAST_PTR = ADDR_W'(DEPTH - 1);

  logic [CNT_W-1:0] occupancy;

  assign emptyFlag = (occupancy == '0);
  assign fullFlag  = (occupancy == FULL_CNT);
  assign halfFlag  = (occupancy >= HALF_CNT);

  always_comb begin
    strobes.flush = fifoDisable;
    strobes.push  = wrStrobe & ~fifoDisable & ~fullFlag;
    strobes.pop   = rdStrobe & ~fifoDisable & ~emptyFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occupancy <= '0;
      wrAddr    <= '0;
      rdAddr    <= '0;
    end else if (strobes.flush) begin
      occupancy <= '0;
      wrAddr    <= '0;
      rdAddr    <= '0;
    end else begin
      occupancy <= occupancy + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
      if (strobes.push) wrAddr <= (wrAddr == LAST_PTR) ? '0 : wrAddr + 1'b1;
      if (strobes.pop)  rdAddr <= (rdAddr == LAST_PTR) ? '0 : rdAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= 1'b0;
      eocPulse <= 1'b0;
    end else begin
      eocPulse <= wrStrobe & ~fifoDisable;
      if (fifoDisable)                overflow <= 1'b0;
      else if (wrStrobe && fullFlag)  overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/acq_fifo_dpath.sv
module acq_fifo_dpath
  import acq_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobes.pop) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo
  import acq_fifo_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 1024,
  parameter int RANGE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrStrobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdStrobe,
  output logic [DATA_W-1:0]  rdData,
  input  logic               fifoDisable,
  input  logic               irqSrcSel,
  input  logic [RANGE_W-1:0] rangeCode,
  input  logic               convBusy,
  output logic [7:0]         statusByte,
  output logic               overflow,
  output logic               irqReq
);
  localparam int ADDR_W = $clog2(DEPTH);

  fifoStrobe_t       strobes;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic              emptyFlag;
  logic              halfFlag;
  logic              fullFlag;
  logic              eocPulse;

  acq_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .fifoDisable(fifoDisable), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .emptyFlag(emptyFlag), .halfFlag(halfFlag),
    .fullFlag(fullFlag), .overflow(overflow), .eocPulse(eocPulse)
  );

  acq_fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

  always_comb begin
    statusByte                 = '0;
    statusByte[RANGE_W-1:0]    = rangeCode;
    statusByte[STAT_EMPTY_BIT] = ~emptyFlag;
    statusByte[STAT_HALF_BIT]  = ~halfFlag;
    statusByte[STAT_FULL_BIT]  = ~fullFlag;
    statusByte[STAT_BUSY_BIT]  = ~convBusy;
  end

  assign irqReq = irqSrcSel ? halfFlag : eocPulse;
endmodule

// File: rtl/acq_sample_fifo_chk.sv
module acq_sample_fifo_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic              fifoDisable,
  input logic              irqSrcSel,
  input logic [7:0]        statusByte,
  input logic [DATA_W-1:0] rdData,
  input logic              overflow,
  input logic              irqReq
);
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[6] == 1'b0 && statusByte[4] == 1'b0));

  // R4
  full_implies_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] == 1'b0) |-> (statusByte[5] == 1'b0));

  // R5
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && statusByte[6] == 1'b0 && !rdStrobe && !fifoDisable) |=> (statusByte[6] == 1'b0));

  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && overflow && !fifoDisable) |=> overflow);

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && fifoDisable) |=> (statusByte[4] == 1'b0 && !overflow));

  // R6
  empty_read_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && statusByte[4] == 1'b0 && rdStrobe) |=> $stable(rdData));

  // R8
  eoc_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !irqSrcSel && $past(!irqSrcSel && wrStrobe && !fifoDisable)) |-> irqReq);
endmodule

bind acq_sample_fifo acq_sample_fifo_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
  .fifoDisable(fifoDisable), .irqSrcSel(irqSrcSel), .statusByte(statusByte),
  .rdData(rdData), .overflow(overflow), .irqReq(irqReq)
);

// File: tb/acq_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module acq_sample_fifo_tb_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 1024;
  localparam int HALF   = DEPTH / 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrStrobe = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdStrobe = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              fifoDisable = 1'b0;
  logic              irqSrcSel = 1'b0;
  logic [2:0]        rangeCode = 3'd0;
  logic              convBusy = 1'b0;
  logic [7:0]        statusByte;
  logic              overflow;
  logic              irqReq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] model[$];
  logic [DATA_W-1:0] expRd = '0;
  bit expOvf = 1'b0;
  bit expEoc = 1'b0;

  always #2.5 clk = ~clk;

  acq_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RANGE_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdData(rdData), .fifoDisable(fifoDisable),
    .irqSrcSel(irqSrcSel), .rangeCode(rangeCode), .convBusy(convBusy),
    .statusByte(statusByte), .overflow(overflow), .irqReq(irqReq)
  );

  function automatic logic [7:0] expStatus(int sz, logic busy, logic [2:0] rng);
    return {~busy, ~(sz == DEPTH), ~(sz >= HALF), ~(sz == 0), 1'b0, rng};
  endfunction

  function automatic logic expIrq(int sz, logic sel, bit eoc);
    return sel ? (sz >= HALF) : eoc;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic verifyAll();
    check("R2 rdData order (R10 latency)", 32'(rdData), 32'(expRd));
    check("R3 statusByte", 32'(statusByte), 32'(expStatus(model.size(), convBusy, rangeCode)));
    check("R5 overflow", 32'(overflow), 32'(expOvf));
    check("R8 irqReq", 32'(irqReq), 32'(expIrq(model.size(), irqSrcSel, expEoc)));
  endtask

  // one clock: drive after a falling edge, update model at the rising edge, sample at next falling edge
  task automatic doCycle(input bit w, input logic [DATA_W-1:0] d, input bit r, input bit dis);
    bit canPush;
    bit canPop;
    wrStrobe = w; wrData = d; rdStrobe = r; fifoDisable = dis;
    @(posedge clk);
    if (dis) begin
      model.delete();
      expOvf = 1'b0;
      expEoc = 1'b0;
    end else begin
      canPush = model.size() < DEPTH;
      canPop  = model.size() > 0;
      if (w && !canPush) expOvf = 1'b1;
      if (r && canPop) expRd = model.pop_front();
      if (w && canPush) model.push_back(d);
      expEoc = w;
    end
    @(negedge clk);
    wrStrobe = 1'b0; rdStrobe = 1'b0; fifoDisable = 1'b0;
    verifyAll();
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] held;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status at reset", 32'(statusByte), 32'(expStatus(0, 1'b0, 3'd0)));
    check("R1 rdData at reset", 32'(rdData), 32'h0);
    check("R1 overflow at reset", 32'(overflow), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    verifyAll();

    // R2 and R10: ordered write then read
    doCycle(1, 16'hA001, 0, 0);
    doCycle(1, 16'hB002, 0, 0);
    doCycle(1, 16'hC003, 0, 0);
    doCycle(0, 0, 1, 0);
    check("R10 first pop", 32'(rdData), 32'hA001);
    doCycle(0, 0, 1, 0);
    doCycle(0, 0, 1, 0);
    check("R2 third pop", 32'(rdData), 32'hC003);

    // R6: read while empty
    held = rdData;
    doCycle(0, 0, 1, 0);
    doCycle(0, 0, 1, 0);
    check("R6 empty read keeps rdData", 32'(rdData), 32'(held));
    doCycle(1, 16'h1234, 0, 0);
    doCycle(0, 0, 1, 0);
    check("R6 pointers unmoved", 32'(rdData), 32'h1234);

    // R9: simultaneous read and write
    doCycle(1, 16'h0101, 0, 0);
    doCycle(1, 16'h0202, 1, 0);
    check("R9 pop during push", 32'(rdData), 32'h0101);
    check("R9 occupancy kept (not empty)", 32'(statusByte[4]), 32'h1);
    doCycle(0, 0, 1, 0);
    check("R9 pushed sample", 32'(rdData), 32'h0202);

    // R4 / R5: fill to the boundaries with half-full interrupt source
    irqSrcSel = 1'b1;
    for (int i = 0; i < HALF - 1; i++) doCycle(1, DATA_W'(i), 0, 0);
    check("R4 half bit at 511", 32'(statusByte[5]), 32'h1);
    check("R8 irq low below half", 32'(irqReq), 32'h0);
    doCycle(1, DATA_W'(HALF - 1), 0, 0);
    check("R4 half bit at 512", 32'(statusByte[5]), 32'h0);
    check("R8 irq at half", 32'(irqReq), 32'h1);
    for (int i = HALF; i < DEPTH; i++) doCycle(1, DATA_W'(i), 0, 0);
    check("R5 full bit", 32'(statusByte[6]), 32'h0);
    doCycle(1, 16'hDEAD, 0, 0);
    check("R5 overflow set", 32'(overflow), 32'h1);
    irqSrcSel = 1'b0;
    doCycle(1, 16'hBEEF, 0, 0);
    check("R8 eoc pulse on dropped write", 32'(irqReq), 32'h1);
    doCycle(0, 0, 1, 0);
    check("R5 data preserved", 32'(rdData), 32'h0);
    // drain across the pointer wrap
    for (int i = 1; i < DEPTH; i++) doCycle(0, 0, 1, 0);
    check("R2 last after wrap", 32'(rdData), 32'(DEPTH - 1));
    check("R5 overflow sticky", 32'(overflow), 32'h1);

    // R7 flush sequence
    doCycle(1, 16'h7777, 0, 0);
    doCycle(1, 16'h8888, 0, 1);
    check("R7 empty during disable", 32'(statusByte[4]), 32'h0);
    check("R7 overflow cleared", 32'(overflow), 32'h0);
    doCycle(0, 0, 0, 0);
    check("R7 empty after enable", 32'(statusByte[4]), 32'h0);
    held = rdData;
    doCycle(0, 0, 1, 0);
    check("R7 nothing left to read", 32'(rdData), 32'(held));

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      irqSrcSel = 1'($urandom_range(0, 1));
      convBusy  = 1'($urandom_range(0, 1));
      rangeCode = 3'($urandom_range(0, 7));
      doCycle(($urandom_range(0, 99) < 55), DATA_W'($urandom),
              ($urandom_range(0, 99) < 45), ($urandom_range(0, 199) == 0));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule